// File: doc/BRIEF.md
# Data Address Compare Debug Unit

This unit watches data-side memory accesses and records debug events when an access address satisfies a programmable comparison against two compare registers. Software loads the two compare values and a control word through simple write strobes. The control word selects how the two registers are used. They can be two independent equality checks, a value with a mask, or the two bounds of an inclusive or exclusive address range. The control word also sets a per-compare condition on a data-space state bit and enables read and write events separately for each compare.

Each compare has a read-event bit and a write-event bit in a 4-bit sticky status register. The access type decides which of the two bits is set. Software clears status bits by writing ones under a mask. Any debug or trace logic can read the status vector directly.

Top module: `dac_debug_unit`

## Requirements
- R1: After reset, both compare registers, the control word and the status vector `sts_q` are all zero.
- R2: Mode code 0 (control bits [1:0]) is exact compare. Compare 0 matches when the address equals compare register 1. Compare 1 matches when the address equals compare register 2.
- R3: Mode code 1 is masked match. Both compares match when (address AND cmp2) equals (cmp1 AND cmp2).
- R4: Mode code 2 is inclusive range. Both compares match when cmp1 <= address < cmp2, compared as unsigned values.
- R5: Mode code 3 is exclusive range. Both compares match when address < cmp1 or address >= cmp2, compared as unsigned values.
- R6: Each compare has a data-space qualifier: control bits [3:2] for compare 0 and [5:4] for compare 1. Code 0 places no condition on the data-space bit. Code 2 allows an event only when `acc_ds` is 0. Code 3 allows an event only when `acc_ds` is 1.
- R7: Qualifier code 1 never lets its compare produce an event.
- R8: Read and write events have separate enables per compare: bits [6] and [7] for compare 0, bits [8] and [9] for compare 1. A read sets status bit 2k for compare k, and a write sets bit 2k+1.
- R9: A status bit is set on the clock edge after a qualifying access is presented with `acc_valid` high. With `acc_valid` low, no status bit is set.
- R10: When `sts_w1c_we` is high, each status bit whose mask bit is 1 is cleared on the next edge. Bits whose mask bit is 0 are left unchanged.
- R11: If an event sets a status bit in the same cycle that a write-one-to-clear targets it, the bit ends up set.
- R12: A status bit stays set until it is cleared by write-one-to-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Data access strobe |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_ds | input | 1 | Data-space state bit |
| cfg_cmp1_we | input | 1 | Load compare register 1 from `cfg_wdata` |
| cfg_cmp2_we | input | 1 | Load compare register 2 from `cfg_wdata` |
| cfg_ctrl_we | input | 1 | Load the control word from `cfg_wdata[9:0]` |
| cfg_wdata | input | 32 | Configuration write data |
| sts_w1c_we | input | 1 | Write-one-to-clear strobe for the status vector |
| sts_w1c_mask | input | 4 | Bits to clear |
| sts_q | output | 4 | Sticky event status: {cmp1 write, cmp1 read, cmp0 write, cmp0 read} |

## Verification
The assertions assume that in the paired modes (masked match and both ranges) both compares carry the same qualifier. Results for mismatched qualifiers in those modes are left open. They also assume that every input is stable for the whole clock cycle around the rising edge. The stimulus drives all inputs on the falling edge and always programs equal qualifiers before it enters a paired mode. It changes configuration only in cycles that have no access, so every access is judged against configuration that has already settled.

// File: rtl/dac_pkg.sv
package dac_pkg;

   typedef enum logic [1:0] {
      MODE_EXACT = 2'b00,
      MODE_MASK  = 2'b01,
      MODE_INCL  = 2'b10,
      MODE_EXCL  = 2'b11
   } dac_mode_e;

   typedef enum logic [1:0] {
      QUAL_ANY  = 2'b00,
      QUAL_RSVD = 2'b01,
      QUAL_DS0  = 2'b10,
      QUAL_DS1  = 2'b11
   } dac_qual_e;

   typedef struct packed {
      logic      wr_en1;
      logic      rd_en1;
      logic      wr_en0;
      logic      rd_en0;
      dac_qual_e qual1;
      dac_qual_e qual0;
      dac_mode_e mode;
   } dac_ctrl_t;

   localparam int CTRL_W = $bits(dac_ctrl_t);
   localparam int NUM_CMP = 2;
   localparam int STS_W = 2 * NUM_CMP;

endpackage

// File: rtl/dac_cfg_regs.sv
module dac_cfg_regs
   import dac_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp1_we,
   input  logic              cmp2_we,
   input  logic              ctrl_we,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] cmp1_q,
   output logic [ADDR_W-1:0] cmp2_q,
   output dac_ctrl_t         ctrl_q
);

   generate
      if (ADDR_W < CTRL_W) begin : g_bad_width
         $error("dac_cfg_regs: ADDR_W must hold the control word");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp1_q <= '0;
         cmp2_q <= '0;
         ctrl_q <= '0;
      end else begin
         if (cmp1_we) cmp1_q <= wdata;
         if (cmp2_we) cmp2_q <= wdata;
         if (ctrl_we) ctrl_q <= dac_ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

endmodule

// File: rtl/dac_match.sv
module dac_match
   import dac_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter bit RANGE_MODES  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] cmp1,
   input  logic [ADDR_W-1:0] cmp2,
   input  dac_mode_e         mode,
   output logic [1:0]        raw_hit
);

   logic eq1, eq2, mask_eq;
   logic in_range, out_range;

   assign eq1     = (addr == cmp1);
   assign eq2     = (addr == cmp2);
   assign mask_eq = ((addr & cmp2) == (cmp1 & cmp2));

   generate
      if (RANGE_MODES) begin : g_range
         logic ge_lo, lt_hi;
         assign ge_lo     = (addr >= cmp1);
         assign lt_hi     = (addr <  cmp2);
         assign in_range  = ge_lo & lt_hi;
         assign out_range = ~ge_lo | ~lt_hi;
      end else begin : g_no_range
         assign in_range  = 1'b0;
         assign out_range = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         MODE_EXACT: raw_hit = {eq2, eq1};
         MODE_MASK:  raw_hit = {2{mask_eq}};
         MODE_INCL:  raw_hit = {2{in_range}};
         MODE_EXCL:  raw_hit = {2{out_range}};
         default:    raw_hit = 2'b00;
      endcase
   end

endmodule

// File: rtl/dac_qual_gate.sv
module dac_qual_gate
   import dac_pkg::*;
(
   input  logic      raw_hit,
   input  dac_qual_e qual,
   input  logic      ds,
   input  logic      valid,
   input  logic      is_write,
   input  logic      rd_en,
   input  logic      wr_en,
   output logic [1:0] set_rw
);

   logic ds_ok;

   always_comb begin
      unique case (qual)
         QUAL_ANY:  ds_ok = 1'b1;
         QUAL_DS0:  ds_ok = ~ds;
         QUAL_DS1:  ds_ok = ds;
         default:   ds_ok = 1'b0;
      endcase
   end

   logic hit;
   assign hit       = valid & raw_hit & ds_ok;
   assign set_rw[0] = hit & ~is_write & rd_en;
   assign set_rw[1] = hit &  is_write & wr_en;

endmodule

// File: rtl/dac_status.sv
module dac_status #(
   parameter int NBITS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_vec,
   input  logic             clr_we,
   input  logic [NBITS-1:0] clr_mask,
   output logic [NBITS-1:0] sts_q
);

   generate
      if (NBITS < 1) begin : g_bad_bits
         $error("dac_status: NBITS must be positive");
      end
   endgenerate

   logic [NBITS-1:0] clr_eff;
   assign clr_eff = clr_we ? clr_mask : '0;

   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)          sts_q[b] <= 1'b0;
         else if (set_vec[b]) sts_q[b] <= 1'b1;
         else if (clr_eff[b]) sts_q[b] <= 1'b0;
      end
   end

endmodule

// File: rtl/dac_debug_unit.sv
module dac_debug_unit
   import dac_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter bit RANGE_MODES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              acc_ds,
   input  logic              cfg_cmp1_we,
   input  logic              cfg_cmp2_we,
   input  logic              cfg_ctrl_we,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              sts_w1c_we,
   input  logic [STS_W-1:0]  sts_w1c_mask,
   output logic [STS_W-1:0]  sts_q
);

   logic [ADDR_W-1:0] cmp1_q, cmp2_q;
   dac_ctrl_t         ctrl_q;
   logic [1:0]        raw_hit;
   logic [STS_W-1:0]  evt_set;

   dac_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp1_we (cfg_cmp1_we),
      .cmp2_we (cfg_cmp2_we),
      .ctrl_we (cfg_ctrl_we),
      .wdata   (cfg_wdata),
      .cmp1_q  (cmp1_q),
      .cmp2_q  (cmp2_q),
      .ctrl_q  (ctrl_q)
   );

   dac_match #(.ADDR_W(ADDR_W), .RANGE_MODES(RANGE_MODES)) u_match (
      .addr    (acc_addr),
      .cmp1    (cmp1_q),
      .cmp2    (cmp2_q),
      .mode    (ctrl_q.mode),
      .raw_hit (raw_hit)
   );

   dac_qual_e  qual_v  [NUM_CMP];
   logic       rden_v  [NUM_CMP];
   logic       wren_v  [NUM_CMP];

   assign qual_v[0] = ctrl_q.qual0;
   assign qual_v[1] = ctrl_q.qual1;
   assign rden_v[0] = ctrl_q.rd_en0;
   assign rden_v[1] = ctrl_q.rd_en1;
   assign wren_v[0] = ctrl_q.wr_en0;
   assign wren_v[1] = ctrl_q.wr_en1;

   for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
      dac_qual_gate u_gate (
         .raw_hit  (raw_hit[k]),
         .qual     (qual_v[k]),
         .ds       (acc_ds),
         .valid    (acc_valid),
         .is_write (acc_write),
         .rd_en    (rden_v[k]),
         .wr_en    (wren_v[k]),
         .set_rw   (evt_set[2*k +: 2])
      );
   end

   dac_status #(.NBITS(STS_W)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (evt_set),
      .clr_we   (sts_w1c_we),
      .clr_mask (sts_w1c_mask),
      .sts_q    (sts_q)
   );

endmodule

// File: rtl/dac_debug_unit_chk.sv
module dac_debug_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_valid,
   input logic       acc_write,
   input logic       sts_w1c_we,
   input logic [3:0] sts_w1c_mask,
   input logic [3:0] sts_q,
   input logic [3:0] evt_set,
   input logic [1:0] qual0,
   input logic [1:0] qual1
);

   AST_NO_SET_WITHOUT_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> ((sts_q & ~$past(sts_q)) == 4'b0000)); // R9

   AST_READ_NOT_WRITE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write) |=> ((sts_q & ~$past(sts_q) & 4'b1010) == 4'b0000)); // R8

   AST_WRITE_NOT_READ_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write) |=> ((sts_q & ~$past(sts_q) & 4'b0101) == 4'b0000)); // R8

   AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set != 4'b0000) |=> ((sts_q & $past(evt_set)) == $past(evt_set))); // R11

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      sts_w1c_we |=> ((sts_q & $past(sts_w1c_mask) & ~$past(evt_set)) == 4'b0000)); // R10

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(sts_q) & ~($past(sts_w1c_we) ? $past(sts_w1c_mask) : 4'b0000))
                 & ~sts_q) == 4'b0000)); // R12

   AST_RSVD_QUAL0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (qual0 == 2'b01) |-> (evt_set[1:0] == 2'b00)); // R7

   AST_RSVD_QUAL1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (qual1 == 2'b01) |-> (evt_set[3:2] == 2'b00)); // R7

endmodule

bind dac_debug_unit dac_debug_unit_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_valid    (acc_valid),
   .acc_write    (acc_write),
   .sts_w1c_we   (sts_w1c_we),
   .sts_w1c_mask (sts_w1c_mask),
   .sts_q        (sts_q),
   .evt_set      (evt_set),
   .qual0        (ctrl_q.qual0),
   .qual1        (ctrl_q.qual1)
);

// File: tb/tb_dac_debug_unit.sv
module tb_dac_debug_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        acc_ds = 1'b0;
   logic        cfg_cmp1_we = 1'b0, cfg_cmp2_we = 1'b0, cfg_ctrl_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        sts_w1c_we = 1'b0;
   logic [3:0]  sts_w1c_mask = '0;
   logic [3:0]  sts_q;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dac_debug_unit dut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write), .acc_ds(acc_ds),
      .cfg_cmp1_we(cfg_cmp1_we), .cfg_cmp2_we(cfg_cmp2_we), .cfg_ctrl_we(cfg_ctrl_we),
      .cfg_wdata(cfg_wdata),
      .sts_w1c_we(sts_w1c_we), .sts_w1c_mask(sts_w1c_mask),
      .sts_q(sts_q)
   );

   // reference state, built from the requirements
   logic [31:0] m_cmp1 = '0, m_cmp2 = '0;
   logic [9:0]  m_ctrl = '0;
   logic [3:0]  m_sts  = '0;

   typedef struct { logic [3:0] exp; string tag; } item_t;
   item_t sb_q[$];

   function automatic logic qual_ok(input logic [1:0] q, input logic ds);
      case (q)
         2'b00:   return 1'b1;
         2'b10:   return !ds;
         2'b11:   return ds;
         default: return 1'b0;            // R7 reserved code
      endcase
   endfunction

   function automatic logic [3:0] model_set(input logic [31:0] a, input logic wr, input logic ds);
      logic [1:0] m;
      logic [3:0] s;
      case (m_ctrl[1:0])
         2'b00: m = {a == m_cmp2, a == m_cmp1};
         2'b01: m = {2{(a & m_cmp2) == (m_cmp1 & m_cmp2)}};
         2'b10: m = {2{(a >= m_cmp1) && (a < m_cmp2)}};
         default: m = {2{(a < m_cmp1) || (a >= m_cmp2)}};
      endcase
      s = '0;
      if (m[0] && qual_ok(m_ctrl[3:2], ds)) begin
         s[0] = !wr && m_ctrl[6];
         s[1] =  wr && m_ctrl[7];
      end
      if (m[1] && qual_ok(m_ctrl[5:4], ds)) begin
         s[2] = !wr && m_ctrl[8];
         s[3] =  wr && m_ctrl[9];
      end
      return s;
   endfunction

   // driver: one cycle of stimulus, expected status pushed before the edge
   task automatic cycle(input logic v, input logic [31:0] a, input logic wr, input logic ds,
                        input logic cw, input logic [3:0] cm, input string tag);
      item_t it;
      logic [3:0] s;
      @(negedge clk);
      acc_valid = v; acc_addr = a; acc_write = wr; acc_ds = ds;
      sts_w1c_we = cw; sts_w1c_mask = cm;
      s = v ? model_set(a, wr, ds) : 4'b0000;
      m_sts = (m_sts & ~(cw ? cm : 4'b0000)) | s;
      it.exp = m_sts; it.tag = tag;
      sb_q.push_back(it);
      @(posedge clk);
   endtask

   task automatic access(input logic [31:0] a, input logic wr, input logic ds, input string tag);
      cycle(1'b1, a, wr, ds, 1'b0, 4'b0000, tag);
   endtask

   task automatic clear_all(input string tag);
      cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, 4'b1111, tag);
   endtask

   task automatic cfg(input logic [31:0] c1, input logic [31:0] c2, input logic [9:0] ctl);
      @(negedge clk);
      acc_valid = 1'b0; sts_w1c_we = 1'b0;
      cfg_cmp1_we = 1'b1; cfg_cmp2_we = 1'b0; cfg_ctrl_we = 1'b0; cfg_wdata = c1;
      @(negedge clk);
      cfg_cmp1_we = 1'b0; cfg_cmp2_we = 1'b1; cfg_wdata = c2;
      @(negedge clk);
      cfg_cmp2_we = 1'b0; cfg_ctrl_we = 1'b1; cfg_wdata = {22'b0, ctl};
      @(negedge clk);
      cfg_ctrl_we = 1'b0;
      m_cmp1 = c1; m_cmp2 = c2; m_ctrl = ctl;
   endtask

   // monitor: pop and compare after every edge that carries an item
   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_vec++;
         if (sts_q !== it.exp) begin
            n_bad++;
            $display("FAIL %s: sts_q=%b expected=%b", it.tag, sts_q, it.exp);
         end
      end
   end

   // ctrl = {wr1,rd1,wr0,rd0,q1[1:0],q0[1:0],mode[1:0]}
   localparam logic [3:0] EN_ALL = 4'b1111;

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_vec++;
      if (sts_q !== 4'b0000) begin
         n_bad++;
         $display("FAIL R1: reset sts_q=%b expected=0000", sts_q);
      end
      rst_n = 1'b1;
      cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 4'b0000, "R1 idle after reset");
      access(32'h0000_0000, 1'b0, 1'b0, "R1 zero config no enables");

      // exact mode
      cfg(32'h0000_1000, 32'h0000_2000, {EN_ALL, 2'b00, 2'b00, 2'b00});
      access(32'h0000_1000, 1'b0, 1'b0, "R2 exact cmp0 read");
      access(32'h0000_2000, 1'b1, 1'b0, "R2 exact cmp1 write");
      access(32'h0000_1004, 1'b0, 1'b0, "R2 exact miss");
      clear_all("R10 clear all");
      cycle(1'b0, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 4'b0000, "R9 no strobe");
      access(32'h0000_2000, 1'b0, 1'b0, "R2 exact cmp1 read");
      access(32'h0000_1000, 1'b1, 1'b0, "R8 exact cmp0 write");
      cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 4'b0000, "R12 sticky");
      clear_all("R10 clear all");

      // enables
      cfg(32'h0000_1000, 32'h0000_2000, {4'b1110, 2'b00, 2'b00, 2'b00});
      access(32'h0000_1000, 1'b0, 1'b0, "R8 read disabled cmp0");
      access(32'h0000_1000, 1'b1, 1'b0, "R8 write enabled cmp0");
      clear_all("R10 clear all");

      // masked match
      cfg(32'hABCD_0000, 32'hFFFF_0000, {EN_ALL, 2'b00, 2'b00, 2'b01});
      access(32'hABCE_0000, 1'b0, 1'b0, "R3 mask miss");
      access(32'hABCD_1234, 1'b0, 1'b0, "R3 mask hit read");
      access(32'hABCD_FFFF, 1'b1, 1'b0, "R3 mask hit write");
      clear_all("R10 clear all");

      // inclusive range
      cfg(32'h0000_0100, 32'h0000_0200, {EN_ALL, 2'b00, 2'b00, 2'b10});
      access(32'h0000_00FF, 1'b0, 1'b0, "R4 below low bound");
      access(32'h0000_0200, 1'b0, 1'b0, "R4 at high bound");
      access(32'h0000_0100, 1'b0, 1'b0, "R4 at low bound");
      clear_all("R10 clear all");
      access(32'h0000_01FF, 1'b1, 1'b0, "R4 top inside");
      clear_all("R10 clear all");

      // exclusive range
      cfg(32'h0000_0100, 32'h0000_0200, {EN_ALL, 2'b00, 2'b00, 2'b11});
      access(32'h0000_0100, 1'b0, 1'b0, "R5 low bound inside");
      access(32'h0000_01FF, 1'b1, 1'b0, "R5 high minus one");
      access(32'h0000_00FF, 1'b0, 1'b0, "R5 below low");
      clear_all("R10 clear all");
      access(32'h0000_0200, 1'b1, 1'b0, "R5 at high bound");
      access(32'hFFFF_FFFF, 1'b0, 1'b0, "R5 top of space");
      clear_all("R10 clear all");

      // qualifiers in exact mode
      cfg(32'h0000_1000, 32'h0000_1000, {EN_ALL, 2'b11, 2'b10, 2'b00});
      access(32'h0000_1000, 1'b0, 1'b1, "R6 ds=1 only cmp1");
      clear_all("R10 clear all");
      access(32'h0000_1000, 1'b0, 1'b0, "R6 ds=0 only cmp0");
      clear_all("R10 clear all");
      cfg(32'h0000_1000, 32'h0000_1000, {EN_ALL, 2'b00, 2'b01, 2'b00});
      access(32'h0000_1000, 1'b1, 1'b0, "R7 reserved cmp0 silent ds0");
      access(32'h0000_1000, 1'b0, 1'b1, "R7 reserved cmp0 silent ds1");
      clear_all("R10 clear all");

      // write-one-to-clear details
      cfg(32'h0000_1000, 32'h0000_1000, {EN_ALL, 2'b00, 2'b00, 2'b00});
      access(32'h0000_1000, 1'b0, 1'b0, "R8 both reads");
      access(32'h0000_1000, 1'b1, 1'b0, "R8 both writes");
      cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, 4'b0000, "R10 zero mask no effect");
      cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, 4'b0101, "R10 partial clear");
      cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 4'b1111, "R10 mask without strobe");
      cycle(1'b1, 32'h0000_1000, 1'b0, 1'b0, 1'b1, 4'b0101, "R11 set beats clear");
      cycle(1'b1, 32'h0000_1000, 1'b1, 1'b0, 1'b1, 4'b0101, "R11 clear others during set");
      clear_all("R10 final clear");
      cycle(1'b0, '0, 1'b0, 1'b0, 1'b0, 4'b0000, "R12 remains clear");

      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule